// File: doc/BRIEF.md
# Cascadable Synchronous Loadable Binary Counter

A 4-bit synchronous binary up counter intended as one slice of a wider counter. All state changes occur on the rising clock edge. A synchronous active-low clear forces the count to zero, and a synchronous active-low load copies a 4-bit data word into the count. When neither is asserted, the count advances by one only when both count enables are high.

The two enables are not interchangeable. The plain enable gates counting only. The carry enable gates counting and also qualifies the terminal-count output. Each stage's terminal-count output can therefore drive the carry enable of the next stage. The chain then forms a look-ahead carry, with no external gates: a higher slice advances only when every slice below it sits at all ones.

Top module: `casc_counter`

## Requirements
- R1: When `clr_n` is low at a rising edge, `q` becomes 0000 after that edge. This holds whatever the values of `load_n`, `en_cnt` and `en_carry`.
- R2: When `clr_n` is high and `load_n` is low at a rising edge, `q` becomes the value on `din`. This holds whatever the values of the two enables.
- R3: When `clr_n` and `load_n` are both high and `en_cnt` and `en_carry` are both high at a rising edge, `q` becomes the old value plus one.
- R4: When `clr_n` and `load_n` are both high and at least one of `en_cnt` or `en_carry` is low, `q` keeps its value across the edge.
- R5: `tc` is a combinational output. It is 1 exactly when `q` is 1111 and `en_carry` is 1. `en_cnt` has no effect on it.
- R6: Counting from 1111 wraps to 0000.
- R7: Three instances can be chained as follows. The lowest stage has both enables high. Each higher stage has `en_cnt` high and its `en_carry` driven by the `tc` of the stage below. Read as a 12-bit value, the three counts then step through 0 to 4095 in order, one step per clock, and wrap to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| en_cnt | input | 1 | Count enable that does not affect `tc` |
| en_carry | input | 1 | Count enable that also qualifies `tc` |
| din | input | 4 | Parallel load data |
| q | output | 4 | Current count |
| tc | output | 1 | Terminal count: `q` is all ones and `en_carry` is high |

## Verification
The bench loads every 4-bit value under every enable combination. It then applies one more edge to test advance versus hold. A design that ignored one enable, or that let the enables block a load, would show a wrong value after that edge. The bench also sets clear together with load and both enables. This catches a priority inversion, which would leave the loaded or incremented value instead of zero. The `tc` sweep covers `q` = 15 with `en_carry` low and with `en_cnt` toggling, which exposes a `tc` that ignores the carry enable or depends on the wrong enable. The 12-bit chain run checks every one of the 4096 steps. Carry gated by the wrong enable would make the upper slice advance early or repeat values.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_STEP  = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } cnt_op_e;

  // Priority: clear over load over counting.
  function automatic cnt_op_e pick_op(input logic clr_n, input logic load_n,
                                      input logic en_a, input logic en_b);
    if (!clr_n)            return OP_CLEAR;
    else if (!load_n)      return OP_LOAD;
    else if (en_a && en_b) return OP_STEP;
    else                   return OP_HOLD;
  endfunction

  // Increment modulo 2**W, written as an explicit wrap.
  function automatic logic [31:0] step_val(input logic [31:0] v, input int w);
    logic [31:0] top;
    top = (32'd1 << w) - 32'd1;
    return (v == top) ? 32'd0 : v + 32'd1;
  endfunction

endpackage

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
  import cnt_pkg::*;
(
  input  logic    clr_n,
  input  logic    load_n,
  input  logic    en_cnt,
  input  logic    en_carry,
  output cnt_op_e op
);
  always_comb op = pick_op(clr_n, load_n, en_cnt, en_carry);
endmodule

// File: rtl/cnt_next.sv
module cnt_next
  import cnt_pkg::*;
#(
  parameter int W = 4
) (
  input  cnt_op_e        op,
  input  logic [W-1:0]   cur,
  input  logic [W-1:0]   din,
  output logic [W-1:0]   nxt
);
  logic [31:0] inc_full;
  always_comb inc_full = step_val(32'(cur), W);

  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = '0;
      OP_LOAD:  nxt = din;
      OP_STEP:  nxt = inc_full[W-1:0];
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/cnt_tc.sv
module cnt_tc #(
  parameter int W = 4
) (
  input  logic [W-1:0] cur,
  input  logic         en_carry,
  output logic         tc
);
  logic [W:0] chain;
  assign chain[0] = en_carry;
  for (genvar i = 0; i < W; i++) begin : g_and
    assign chain[i+1] = chain[i] & cur[i];
  end
  assign tc = chain[W];
endmodule

// File: rtl/casc_counter.sv
module casc_counter
  import cnt_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic         en_cnt,
  input  logic         en_carry,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         tc
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  cnt_op_e      op_w;
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  cnt_ctrl u_ctrl (
    .clr_n(clr_n), .load_n(load_n), .en_cnt(en_cnt), .en_carry(en_carry), .op(op_w)
  );

  cnt_next #(.W(W)) u_next (
    .op(op_w), .cur(cnt_q), .din(din), .nxt(cnt_d)
  );

  cnt_tc #(.W(W)) u_tc (
    .cur(cnt_q), .en_carry(en_carry), .tc(tc)
  );

  always_ff @(posedge clk) cnt_q <= cnt_d;
  assign q = cnt_q;

  // Checks start only after a clear has defined the count.
  logic [1:0] armed = 2'b00;
  always_ff @(posedge clk) armed <= {armed[0], armed[0] | ~clr_n};

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!armed[1])
    !clr_n |=> q == '0);                                              // R1
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!armed[1])
    (clr_n && !load_n) |=> q == $past(din));                          // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!armed[1])
    (clr_n && load_n && en_cnt && en_carry && q != ALL_ONES) |=> q == $past(q) + 1'b1); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!armed[1])
    (clr_n && load_n && !(en_cnt && en_carry)) |=> $stable(q));       // R4
  AST_TC_NEEDS_CARRY: assert property (@(posedge clk) disable iff (!armed[1])
    !en_carry |-> !tc);                                               // R5
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!armed[1])
    (tc && en_cnt && clr_n && load_n) |=> q == '0);                   // R6
endmodule

// File: tb/tb_casc_counter.sv
module tb_casc_counter;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  int n_run = 0;
  int n_bad = 0;

  logic clr_n, load_n, en_cnt, en_carry;
  logic [3:0] din, q;
  logic tc;

  casc_counter dut (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_cnt(en_cnt),
    .en_carry(en_carry), .din(din), .q(q), .tc(tc)
  );

  // 12-bit chain
  logic c_clr_n;
  logic [3:0] q0, q1, q2;
  logic t0, t1, t2;
  casc_counter u_s0 (.clk(clk), .clr_n(c_clr_n), .load_n(1'b1), .en_cnt(1'b1),
                     .en_carry(1'b1), .din(4'd0), .q(q0), .tc(t0));
  casc_counter u_s1 (.clk(clk), .clr_n(c_clr_n), .load_n(1'b1), .en_cnt(1'b1),
                     .en_carry(t0), .din(4'd0), .q(q1), .tc(t1));
  casc_counter u_s2 (.clk(clk), .clr_n(c_clr_n), .load_n(1'b1), .en_cnt(1'b1),
                     .en_carry(t1), .din(4'd0), .q(q2), .tc(t2));

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive at falling edge, pass one rising edge, sample 1 ns later.
  task automatic edge_with(input logic c, input logic l, input logic ea,
                           input logic eb, input logic [3:0] d);
    @(negedge clk);
    clr_n = c; load_n = l; en_cnt = ea; en_carry = eb; din = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #3000000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    clr_n = 1'b0; load_n = 1'b1; en_cnt = 1'b0; en_carry = 1'b0; din = 4'd0;
    c_clr_n = 1'b0;

    // R1 reset state
    edge_with(1'b0, 1'b1, 1'b0, 1'b0, 4'd0);
    check("R1 reset", int'(q), 0);

    // R2, R3, R4, R6: load every value under every enable pair, then one more edge
    for (int v = 0; v < 16; v++) begin
      for (int e = 0; e < 4; e++) begin
        edge_with(1'b1, 1'b0, e[0], e[1], 4'(v));
        check("R2 load", int'(q), v);
        edge_with(1'b1, 1'b1, e[0], e[1], 4'(~v));
        if (e == 3) check(v == 15 ? "R6 wrap" : "R3 step", int'(q), (v + 1) % 16);
        else        check("R4 hold", int'(q), v);
      end
    end

    // R1 priority: clear beats load and enables
    edge_with(1'b1, 1'b0, 1'b0, 1'b0, 4'd9);
    edge_with(1'b0, 1'b0, 1'b1, 1'b1, 4'd6);
    check("R1 clear over load", int'(q), 0);
    edge_with(1'b1, 1'b0, 1'b0, 1'b0, 4'd12);
    edge_with(1'b0, 1'b1, 1'b0, 1'b0, 4'd0);
    check("R1 clear idle", int'(q), 0);

    // R5 terminal count sweep, count held by en_carry/en_cnt combinations
    for (int v = 0; v < 16; v++) begin
      edge_with(1'b1, 1'b0, 1'b0, 1'b0, 4'(v));
      for (int e = 0; e < 4; e++) begin
        @(negedge clk);
        load_n = 1'b1; en_cnt = e[0]; en_carry = e[1];
        #1;
        check("R5 tc", int'(tc), (v == 15 && e[1]) ? 1 : 0);
      end
      en_cnt = 1'b0; en_carry = 1'b0;
    end

    // R7 chain: clear, then 4096+3 steps
    @(negedge clk); c_clr_n = 1'b0;
    @(posedge clk); #1;
    check("R7 chain clear", int'({q2, q1, q0}), 0);
    @(negedge clk); c_clr_n = 1'b1;
    for (int i = 1; i <= 4099; i++) begin
      @(posedge clk); #1;
      check("R7 chain step", int'({q2, q1, q0}), i % 4096);
      if (i % 4096 == 4095) check("R7 top tc", int'(t2), 1);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule